// File: doc/BRIEF.md
# Branch and Jump Next-PC Unit

This block chooses the address of the next instruction for a 32-bit processor with one branch delay slot. Each cycle it is given the current PC, the decoded fields of the instruction (major opcode, the sub-opcode carried in the second register field, the function field, the 16-bit signed offset and the 26-bit jump field) and the value already read from the source register. It returns the next PC, a redirect flag, and a request to write a return address into the link register. All outputs are registered, so a decision appears one clock after its inputs are presented.

Four branches test the source value against zero. The test uses only its sign bit and a zero detect. Two further forms jump to an absolute address inside the current 256 MB region, and one of these also writes a return address. A last form jumps to the source value. Anything else, including a branch whose test fails, falls through to PC+4. The return address is PC+8 because the instruction in the delay slot runs before the call takes effect.

Internally the instruction is sorted into one of five flow classes: sequential, conditional, absolute jump, linking jump and register jump. The conditional class carries one of four conditions: negative, non-negative, non-positive and positive. The redirect is then picked from a small set of candidate addresses that are computed in parallel.

Top module: `branch_npc_unit`

## Requirements
- R1: While reset is low, next_pc_o is 0, and taken_o, link_we_o and link_data_o are all 0.
- R2: Opcode 0x01 with sub-opcode 0x00 redirects when rs is negative (bit 31 set). With sub-opcode 0x01 it redirects when rs is zero or positive. Any other sub-opcode under opcode 0x01 falls through.
- R3: Opcode 0x06 with sub-opcode 0x00 redirects when rs is zero or negative. Opcode 0x07 with sub-opcode 0x00 redirects when rs is positive and non-zero. A non-zero sub-opcode under these opcodes falls through.
- R4: A taken branch goes to PC+4 plus the 16-bit offset, sign-extended and shifted left by two. Negative offsets therefore jump backwards.
- R5: Opcode 0x02 always redirects to {(PC+4)[31:28], target[25:0], 2'b00}.
- R6: Opcode 0x03 redirects like R5, sets link_we_o, and drives link_data_o to PC+8. link_idx_o is 31 at all times. For every other instruction link_we_o and link_data_o are 0.
- R7: Opcode 0x00 with function 0x08 redirects to the rs value unchanged. Other function codes fall through.
- R8: A failed branch test, or an instruction outside R2 to R7, gives next_pc_o = PC+4 with taken_o low.
- R9: Outputs change only at a rising clock edge and reflect the inputs sampled at that edge. This gives a latency of one cycle and a new result every cycle.
- R10: All address arithmetic wraps modulo 2^32. A PC of 0xFFFFFFFC falls through to 0, and a link from that PC gives 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pc_i | input | 32 | Address of the current instruction |
| opcode_i | input | 6 | Major opcode |
| subop_i | input | 5 | Sub-opcode for the sign-test branches |
| funct_i | input | 6 | Function field for opcode 0x00 |
| offset_i | input | 16 | Signed branch displacement, in words |
| jtarget_i | input | 26 | Absolute jump field, in words |
| rs_val_i | input | 32 | Value of the source register |
| next_pc_o | output | 32 | Registered next PC |
| taken_o | output | 1 | Registered redirect flag |
| link_we_o | output | 1 | Registered link write request |
| link_data_o | output | 32 | Registered return address |
| link_idx_o | output | 5 | Link register index, always 31 |

## Verification
The linking jump does two things in one cycle: it redirects the PC and it writes a return address. The interesting case is when the incremented PC crosses a 256 MB region boundary, and another case is when PC+8 wraps past the top of the address space. Directed calls placed at 0x0FFFFFFC and 0xFFFFFFFC provoke both. The bench judges the new PC, which must take its upper four bits from PC+4, and the link value, which must be PC+8, in the same sampled cycle. Random linking jumps mixed with every other class then check that the link request never leaks into any other instruction.

// File: rtl/npc_pkg.sv
package npc_pkg;

    localparam int XLEN  = 32;
    localparam int OPW   = 6;
    localparam int SUBW  = 5;
    localparam int FUNW  = 6;

    localparam logic [OPW-1:0]  OPC_SPECIAL = 6'h00;
    localparam logic [OPW-1:0]  OPC_SIGNBR  = 6'h01;
    localparam logic [OPW-1:0]  OPC_JABS    = 6'h02;
    localparam logic [OPW-1:0]  OPC_JLINK   = 6'h03;
    localparam logic [OPW-1:0]  OPC_LEZ     = 6'h06;
    localparam logic [OPW-1:0]  OPC_GTZ     = 6'h07;

    localparam logic [SUBW-1:0] SUB_LTZ     = 5'h00;
    localparam logic [SUBW-1:0] SUB_GEZ     = 5'h01;
    localparam logic [FUNW-1:0] FUN_JREG    = 6'h08;

    typedef enum logic [2:0] {
        FLOW_SEQ,
        FLOW_COND,
        FLOW_JABS,
        FLOW_JLINK,
        FLOW_JREG
    } flow_e;

    typedef enum logic [1:0] {
        CND_NEG,
        CND_NONNEG,
        CND_NONPOS,
        CND_POS
    } cond_e;

endpackage

// File: rtl/npc_decode.sv
module npc_decode
    import npc_pkg::*;
(
    input  logic [OPW-1:0]  opcode,
    input  logic [SUBW-1:0] subop,
    input  logic [FUNW-1:0] funct,
    output flow_e           flow,
    output cond_e           cond
);

    always_comb begin
        flow = FLOW_SEQ;
        cond = CND_NEG;
        unique case (opcode)
            OPC_SIGNBR: begin
                if (subop == SUB_LTZ) begin
                    flow = FLOW_COND;
                    cond = CND_NEG;
                end else if (subop == SUB_GEZ) begin
                    flow = FLOW_COND;
                    cond = CND_NONNEG;
                end
            end
            OPC_LEZ: begin
                if (subop == '0) begin
                    flow = FLOW_COND;
                    cond = CND_NONPOS;
                end
            end
            OPC_GTZ: begin
                if (subop == '0) begin
                    flow = FLOW_COND;
                    cond = CND_POS;
                end
            end
            OPC_JABS:  flow = FLOW_JABS;
            OPC_JLINK: flow = FLOW_JLINK;
            OPC_SPECIAL: begin
                if (funct == FUN_JREG) flow = FLOW_JREG;
            end
            default: flow = FLOW_SEQ;
        endcase
    end

endmodule

// File: rtl/npc_cond.sv
module npc_cond
    import npc_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] rs_val,
    input  cond_e        cond,
    output logic         pass
);

    logic is_neg;
    logic is_zero;

    assign is_neg  = rs_val[W-1];
    assign is_zero = (rs_val == '0);

    always_comb begin
        unique case (cond)
            CND_NEG:    pass = is_neg;
            CND_NONNEG: pass = ~is_neg;
            CND_NONPOS: pass = is_neg | is_zero;
            CND_POS:    pass = ~is_neg & ~is_zero;
            default:    pass = 1'b0;
        endcase
    end

endmodule

// File: rtl/npc_target.sv
module npc_target #(
    parameter int W    = 32,
    parameter int OFFW = 16,
    parameter int TGTW = 26
) (
    input  logic [W-1:0]    pc,
    input  logic [OFFW-1:0] offset,
    input  logic [TGTW-1:0] jfield,
    output logic [W-1:0]    seq_pc,
    output logic [W-1:0]    br_pc,
    output logic [W-1:0]    jabs_pc,
    output logic [W-1:0]    link_pc
);

    localparam int SEXT = W - OFFW - 2;
    localparam int REGW = W - TGTW - 2;

    logic [W-1:0] disp;

    assign seq_pc  = pc + W'(4);
    assign link_pc = pc + W'(8);
    assign disp    = {{SEXT{offset[OFFW-1]}}, offset, 2'b00};
    assign br_pc   = seq_pc + disp;

    generate
        if (REGW > 0) begin : g_region
            assign jabs_pc = {seq_pc[W-1 -: REGW], jfield, 2'b00};
        end else begin : g_flat
            assign jabs_pc = W'({jfield, 2'b00});
        end
    endgenerate

endmodule

// File: rtl/branch_npc_unit.sv
module branch_npc_unit
    import npc_pkg::*;
#(
    parameter int PCW      = 32,
    parameter int OFFW     = 16,
    parameter int TGTW     = 26,
    parameter int IDXW     = 5,
    parameter int LINK_REG = 31
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PCW-1:0]  pc_i,
    input  logic [5:0]      opcode_i,
    input  logic [4:0]      subop_i,
    input  logic [5:0]      funct_i,
    input  logic [OFFW-1:0] offset_i,
    input  logic [TGTW-1:0] jtarget_i,
    input  logic [PCW-1:0]  rs_val_i,
    output logic [PCW-1:0]  next_pc_o,
    output logic            taken_o,
    output logic            link_we_o,
    output logic [PCW-1:0]  link_data_o,
    output logic [IDXW-1:0] link_idx_o
);

    flow_e          flow;
    cond_e          cond;
    logic           cond_pass;
    logic [PCW-1:0] seq_pc, br_pc, jabs_pc, link_pc;

    logic [PCW-1:0] nxt_d;
    logic           tkn_d;
    logic           lwe_d;
    logic [PCW-1:0] ldat_d;

    npc_decode u_dec (
        .opcode (opcode_i),
        .subop  (subop_i),
        .funct  (funct_i),
        .flow   (flow),
        .cond   (cond)
    );

    npc_cond #(.W(PCW)) u_cond (
        .rs_val (rs_val_i),
        .cond   (cond),
        .pass   (cond_pass)
    );

    npc_target #(.W(PCW), .OFFW(OFFW), .TGTW(TGTW)) u_tgt (
        .pc      (pc_i),
        .offset  (offset_i),
        .jfield  (jtarget_i),
        .seq_pc  (seq_pc),
        .br_pc   (br_pc),
        .jabs_pc (jabs_pc),
        .link_pc (link_pc)
    );

    always_comb begin
        nxt_d  = seq_pc;
        tkn_d  = 1'b0;
        lwe_d  = 1'b0;
        ldat_d = '0;
        unique case (flow)
            FLOW_SEQ: ;
            FLOW_COND: begin
                if (cond_pass) begin
                    nxt_d = br_pc;
                    tkn_d = 1'b1;
                end
            end
            FLOW_JABS: begin
                nxt_d = jabs_pc;
                tkn_d = 1'b1;
            end
            FLOW_JLINK: begin
                nxt_d  = jabs_pc;
                tkn_d  = 1'b1;
                lwe_d  = 1'b1;
                ldat_d = link_pc;
            end
            FLOW_JREG: begin
                nxt_d = rs_val_i;
                tkn_d = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            next_pc_o   <= '0;
            taken_o     <= 1'b0;
            link_we_o   <= 1'b0;
            link_data_o <= '0;
        end else begin
            next_pc_o   <= nxt_d;
            taken_o     <= tkn_d;
            link_we_o   <= lwe_d;
            link_data_o <= ldat_d;
        end
    end

    assign link_idx_o = IDXW'(LINK_REG);

endmodule

// File: rtl/branch_npc_unit_chk.sv
module branch_npc_unit_chk #(
    parameter int PCW  = 32,
    parameter int OFFW = 16,
    parameter int TGTW = 26,
    parameter int IDXW = 5
) (
    input logic            clk,
    input logic            rst_n,
    input logic [PCW-1:0]  pc_i,
    input logic [5:0]      opcode_i,
    input logic [4:0]      subop_i,
    input logic [5:0]      funct_i,
    input logic [OFFW-1:0] offset_i,
    input logic [TGTW-1:0] jtarget_i,
    input logic [PCW-1:0]  rs_val_i,
    input logic [PCW-1:0]  next_pc_o,
    input logic            taken_o,
    input logic            link_we_o,
    input logic [PCW-1:0]  link_data_o,
    input logic [IDXW-1:0] link_idx_o
);

    logic past_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    p_link_only_call_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && link_we_o) |-> ($past(opcode_i) == 6'h03 &&
                                    link_data_o == $past(pc_i) + 32'd8));

    p_call_sets_link_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(opcode_i) == 6'h03) |-> (link_we_o && taken_o));

    p_fallthrough_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !taken_o) |-> (next_pc_o == $past(pc_i) + 32'd4));

    p_regjump_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(opcode_i) == 6'h00 && $past(funct_i) == 6'h08)
            |-> (taken_o && next_pc_o == $past(rs_val_i)));

    p_region_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(opcode_i) == 6'h02)
            |-> (taken_o && next_pc_o[1:0] == 2'b00 &&
                 next_pc_o[PCW-1:TGTW+2] == ($past(pc_i) + 32'd4) >> (TGTW+2)));

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $stable(pc_i) && $stable(opcode_i) && $stable(subop_i) &&
         $stable(funct_i) && $stable(offset_i) && $stable(jtarget_i) &&
         $stable(rs_val_i)) |=> $stable(next_pc_o));

endmodule

bind branch_npc_unit branch_npc_unit_chk #(
    .PCW(PCW), .OFFW(OFFW), .TGTW(TGTW), .IDXW(IDXW)
) chk_i (.*);

// File: tb/branch_npc_unit_tb_top.sv
module branch_npc_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pc_i = '0;
    logic [5:0]  opcode_i = '0;
    logic [4:0]  subop_i = '0;
    logic [5:0]  funct_i = '0;
    logic [15:0] offset_i = '0;
    logic [25:0] jtarget_i = '0;
    logic [31:0] rs_val_i = '0;
    logic [31:0] next_pc_o;
    logic        taken_o;
    logic        link_we_o;
    logic [31:0] link_data_o;
    logic [4:0]  link_idx_o;

    int n_run  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    branch_npc_unit dut_i (
        .clk(clk), .rst_n(rst_n), .pc_i(pc_i), .opcode_i(opcode_i),
        .subop_i(subop_i), .funct_i(funct_i), .offset_i(offset_i),
        .jtarget_i(jtarget_i), .rs_val_i(rs_val_i), .next_pc_o(next_pc_o),
        .taken_o(taken_o), .link_we_o(link_we_o), .link_data_o(link_data_o),
        .link_idx_o(link_idx_o)
    );

    function automatic void model(
        input  logic [31:0] pc, input logic [5:0] op, input logic [4:0] sub,
        input  logic [5:0]  fn, input logic [15:0] off, input logic [25:0] tg,
        input  logic [31:0] rs,
        output logic [31:0] nxt, output logic tk, output logic we,
        output logic [31:0] ld);
        logic [31:0] pc4;
        logic        br;
        pc4 = pc + 32'd4;
        nxt = pc4; tk = 1'b0; we = 1'b0; ld = '0; br = 1'b0;
        case (op)
            6'h01: br = (sub == 5'd0 && rs[31]) || (sub == 5'd1 && !rs[31]);
            6'h06: br = (sub == 5'd0) && (rs[31] || rs == 32'd0);
            6'h07: br = (sub == 5'd0) && !rs[31] && rs != 32'd0;
            6'h02: begin nxt = {pc4[31:28], tg, 2'b00}; tk = 1'b1; end
            6'h03: begin nxt = {pc4[31:28], tg, 2'b00}; tk = 1'b1;
                         we = 1'b1; ld = pc + 32'd8; end
            6'h00: if (fn == 6'h08) begin nxt = rs; tk = 1'b1; end
            default: ;
        endcase
        if (br) begin
            nxt = pc4 + {{14{off[15]}}, off, 2'b00};
            tk  = 1'b1;
        end
    endfunction

    function automatic string tag_of(input logic [5:0] op);
        case (op)
            6'h01: return "R2";
            6'h06, 6'h07: return "R3";
            6'h02: return "R5";
            6'h03: return "R6";
            6'h00: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %08h expected %08h", tag, what, got, exp);
        end
    endtask

    task automatic run_one(input string tag, input logic [31:0] pc,
                           input logic [5:0] op, input logic [4:0] sub,
                           input logic [5:0] fn, input logic [15:0] off,
                           input logic [25:0] tg, input logic [31:0] rs);
        logic [31:0] e_nxt, e_ld;
        logic        e_tk, e_we;
        pc_i = pc; opcode_i = op; subop_i = sub; funct_i = fn;
        offset_i = off; jtarget_i = tg; rs_val_i = rs;
        model(pc, op, sub, fn, off, tg, rs, e_nxt, e_tk, e_we, e_ld);
        @(posedge clk);
        @(negedge clk);
        chk(tag, "next_pc", next_pc_o, e_nxt);
        chk(tag, "taken", 32'(taken_o), 32'(e_tk));
        chk(tag, "link_we", 32'(link_we_o), 32'(e_we));
        chk(tag, "link_data", link_data_o, e_ld);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] held;
        void'($urandom(32'd2024));
        pc_i = 32'h0000_1000; opcode_i = 6'h02;
        repeat (3) @(negedge clk);
        chk("R1", "next_pc", next_pc_o, 32'd0);
        chk("R1", "taken", 32'(taken_o), 32'd0);
        chk("R1", "link_we", 32'(link_we_o), 32'd0);
        chk("R1", "link_data", link_data_o, 32'd0);
        chk("R6", "link_idx", 32'(link_idx_o), 32'd31);
        rst_n = 1'b1;

        run_one("R2", 32'h100, 6'h01, 5'd0, 6'h0, 16'h0010, '0, 32'hFFFF_FFFF);
        run_one("R2", 32'h100, 6'h01, 5'd0, 6'h0, 16'h0010, '0, 32'd0);
        run_one("R2", 32'h100, 6'h01, 5'd1, 6'h0, 16'h0010, '0, 32'd0);
        run_one("R2", 32'h100, 6'h01, 5'd1, 6'h0, 16'h0010, '0, 32'h8000_0000);
        run_one("R2", 32'h100, 6'h01, 5'd2, 6'h0, 16'h0010, '0, 32'hFFFF_FFFF);
        run_one("R3", 32'h200, 6'h06, 5'd0, 6'h0, 16'h0004, '0, 32'd0);
        run_one("R3", 32'h200, 6'h06, 5'd0, 6'h0, 16'h0004, '0, 32'd1);
        run_one("R3", 32'h200, 6'h07, 5'd0, 6'h0, 16'h0004, '0, 32'd1);
        run_one("R3", 32'h200, 6'h07, 5'd0, 6'h0, 16'h0004, '0, 32'd0);
        run_one("R3", 32'h200, 6'h07, 5'd3, 6'h0, 16'h0004, '0, 32'd9);
        run_one("R4", 32'h300, 6'h01, 5'd1, 6'h0, 16'hFFFF, '0, 32'd5);
        run_one("R4", 32'h300, 6'h01, 5'd1, 6'h0, 16'h8000, '0, 32'd5);
        run_one("R5", 32'h4000_0010, 6'h02, 5'd0, 6'h0, '0, 26'h3FF_FFFF, '0);
        run_one("R6", 32'h0FFF_FFFC, 6'h03, 5'd0, 6'h0, '0, 26'h000_0040, '0);
        run_one("R7", 32'h500, 6'h00, 5'd0, 6'h08, '0, '0, 32'hDEAD_BEE0);
        run_one("R7", 32'h500, 6'h00, 5'd0, 6'h09, '0, '0, 32'hDEAD_BEE0);
        run_one("R8", 32'h600, 6'h23, 5'd0, 6'h08, 16'h7FFF, 26'h1, 32'h1);
        run_one("R10", 32'hFFFF_FFFC, 6'h2B, 5'd0, 6'h0, '0, '0, '0);
        run_one("R10", 32'hFFFF_FFFC, 6'h03, 5'd0, 6'h0, '0, 26'h10, '0);

        held = next_pc_o;
        pc_i = 32'h0000_7000; opcode_i = 6'h02; jtarget_i = 26'h123;
        #2;
        chk("R9", "hold_before_edge", next_pc_o, held);
        run_one("R9", 32'h0000_7000, 6'h02, 5'd0, 6'h0, '0, 26'h123, '0);
        run_one("R9", 32'h0000_7004, 6'h00, 5'd0, 6'h0, '0, '0, '0);

        for (int i = 0; i < 400; i++) begin
            logic [5:0]  op;
            logic [4:0]  sub;
            logic [31:0] rs;
            case ($urandom_range(0, 7))
                0: op = 6'h00; 1: op = 6'h01; 2: op = 6'h02; 3: op = 6'h03;
                4: op = 6'h06; 5: op = 6'h07; default: op = 6'($urandom);
            endcase
            sub = ($urandom_range(0, 3) == 0) ? 5'($urandom) : 5'($urandom_range(0, 1));
            case ($urandom_range(0, 3))
                0: rs = 32'd0; 1: rs = 32'hFFFF_FFFF; default: rs = $urandom;
            endcase
            run_one(tag_of(op), $urandom & 32'hFFFF_FFFC, op, sub,
                    ($urandom_range(0, 1) == 1) ? 6'h08 : 6'($urandom),
                    16'($urandom), 26'($urandom), rs);
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule